// File: doc/BRIEF.md
# Stereo Serial Audio Receiver

This block turns one serial audio data line into parallel left and right samples. It watches a bit clock, a frame clock and the data line, all of which it samples with the system clock, and picks out the active bit-clock edges itself. Gapped (burst) bit clocks and long pauses between edges are therefore tolerated. Four framing formats are supported: I2S, left-justified, right-justified and a pulse-framed DSP format. The word length is selectable from 16 to 24 bits, and the polarity of each clock can be set.

In the three stereo formats the level of the frame clock tells left from right. The DSP format has a frame pulse at twice the sample rate and carries no channel identity. The receiver pairs consecutive DSP words: the first goes to the left output and the second to the right output. Each completed pair is presented on the outputs together with a one-cycle strobe. The configuration inputs are expected to stay static while a stream is running, and reset is used between changes.

Top module: `stereo_serial_rx`

## Requirements
- R1: `fmt_sel` selects the framing: 00 I2S, 01 left-justified, 10 right-justified, 11 DSP. With all configuration inputs tied low, the block decodes I2S.
- R2: With `bclk_inv` low, data and frame clock are sampled on rising bit-clock edges. With it high, they are sampled on falling edges.
- R3: `lrclk_inv` high inverts the frame clock before any decoding, so every level and edge rule below applies to the inverted signal.
- R4: I2S: a half-frame starts at the first active edge that sees a new frame level. A low level carries the left word, and the MSB is sampled on the second active edge of the half.
- R5: Left-justified: a high frame level carries the left word, and the MSB is sampled on the first active edge of the half (the edge that sees the new level).
- R6: Right-justified: channel sense is as in R5. The word is the last N bits sampled before the active edge that sees the next frame-level change.
- R7: DSP: each rising frame level starts a word, and its MSB is sampled one active edge later. Successive words form pairs: the first is output as left, the second as right.
- R8: The word length N is `word_len`, clamped into 16..24. Data arrives MSB first. Each word appears left-aligned in the 24-bit output with its unused low bits zero.
- R9: Bits that follow the word within a half-frame are ignored. Any number of extra active edges, and idle gaps of any length between edges, leave the decoding unaffected.
- R10: `valid_out` is high for exactly one cycle per completed pair. A right word only completes a pair after a left word has been taken. The sample outputs change only together with the strobe.
- R11: After reset, both samples are zero and `valid_out` is low. No word is taken until a frame boundary has been observed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fmt_sel | input | 2 | Framing format select |
| word_len | input | LEN_W (5) | Word length in bits, clamped into 16..24 |
| bclk_inv | input | 1 | Selects the falling bit-clock edge as the active edge |
| lrclk_inv | input | 1 | Inverts the frame clock |
| bclk_in | input | 1 | Serial bit clock |
| lrclk_in | input | 1 | Serial frame clock |
| sdata_in | input | 1 | Serial data line |
| left_out | output | MAX_W (24) | Left (or first DSP) sample, left-aligned |
| right_out | output | MAX_W (24) | Right (or second DSP) sample, left-aligned |
| valid_out | output | 1 | One-cycle strobe for a new sample pair |

## Verification
The assertions assume that the serial inputs are synchronous to `clk` and hold steady around each bit-clock transition. They also assume that the format, word length and polarity inputs change only while reset is asserted.

The stimulus follows these rules. Every level change is driven on the falling system-clock edge, and each bit-clock phase lasts at least one system cycle. Data and frame clock change only in the inactive bit-clock phase. The DUT is reset before each new configuration. Random idle gaps between bits model gapped bit clocks, and random filler bits in the unused slots check that those slots are ignored.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef enum logic [1:0] {
    FMT_I2S = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_RJ  = 2'b10,
    FMT_DSP = 2'b11
  } ssr_fmt_e;
endpackage

// File: rtl/ssr_bclk_edge.sv
module ssr_bclk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic bclk_inv,
  output logic act_edge
);
  logic lvl_d;
  logic lvl_q;

  // polarity folded in so the active edge is always a rise of lvl_d
  always_comb begin
    lvl_d = bclk_in ^ bclk_inv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b1;
    else        lvl_q <= lvl_d;
  end

  assign act_edge = lvl_d & ~lvl_q;
endmodule

// File: rtl/ssr_slot_track.sv
module ssr_slot_track #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_edge,
  input  logic             frame_lvl,
  input  logic             dsp_mode,
  output logic             bound,
  output logic [CNT_W-1:0] slot_idx,
  output logic             prev_lvl,
  output logic             synced
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             lvl_q, lvl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sync_q, sync_d;
  logic [CNT_W-1:0] idx_now;

  always_comb begin
    if (dsp_mode) bound = act_edge & frame_lvl & ~lvl_q;
    else          bound = act_edge & (frame_lvl ^ lvl_q);

    if (bound)                 idx_now = '0;
    else if (cnt_q != CNT_MAX) idx_now = cnt_q + 1'b1;
    else                       idx_now = cnt_q;

    lvl_d  = lvl_q;
    cnt_d  = cnt_q;
    sync_d = sync_q;
    if (act_edge) begin
      lvl_d  = frame_lvl;
      cnt_d  = idx_now;
      sync_d = sync_q | bound;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      cnt_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      cnt_q  <= cnt_d;
      sync_q <= sync_d;
    end
  end

  assign slot_idx = idx_now;
  assign prev_lvl = lvl_q;
  assign synced   = sync_q;

  // R9: slot position only moves on an active bit-clock edge
  p_idx_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !act_edge |=> $stable(cnt_q));

  // R11: once a boundary has been seen, the block stays in step
  p_sync_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |=> sync_q);
endmodule

// File: rtl/ssr_word_cap.sv
module ssr_word_cap
  import ssr_pkg::*;
#(
  parameter int MAX_W = 24,
  parameter int MIN_W = 16,
  parameter int CNT_W = 6,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_edge,
  input  logic             bound,
  input  logic [CNT_W-1:0] slot_idx,
  input  logic             prev_lvl,
  input  logic             frame_lvl,
  input  logic             synced,
  input  ssr_fmt_e         fmt,
  input  logic [LEN_W-1:0] word_len,
  input  logic             sdata,
  output logic             word_stb,
  output logic [MAX_W-1:0] word_data,
  output logic             word_left
);
  logic [MAX_W-1:0] sh_q, sh_d;
  logic [MAX_W-1:0] shifted, raw, mask;
  logic [LEN_W-1:0] len_eff;
  logic [CNT_W-1:0] last_idx;
  logic             cnt_hit, rj_hit;

  always_comb begin
    if (word_len < LEN_W'(MIN_W))      len_eff = LEN_W'(MIN_W);
    else if (word_len > LEN_W'(MAX_W)) len_eff = LEN_W'(MAX_W);
    else                               len_eff = word_len;

    // the MSB sits one slot late in every format except left-justified
    last_idx = CNT_W'(len_eff) - CNT_W'(1) +
               ((fmt == FMT_LJ) ? {CNT_W{1'b0}} : {{(CNT_W-1){1'b0}}, 1'b1});

    shifted = {sh_q[MAX_W-2:0], sdata};
    cnt_hit = act_edge & synced & (fmt != FMT_RJ) & (slot_idx == last_idx);
    rj_hit  = act_edge & synced & (fmt == FMT_RJ) & bound;
    word_stb = cnt_hit | rj_hit;

    // right-justified takes the history before the boundary bit is shifted in
    raw       = (fmt == FMT_RJ) ? sh_q : shifted;
    mask      = {MAX_W{1'b1}} >> (MAX_W - int'(len_eff));
    word_data = (raw & mask) << (MAX_W - int'(len_eff));

    case (fmt)
      FMT_RJ:  word_left = prev_lvl;
      FMT_I2S: word_left = ~frame_lvl;
      default: word_left = frame_lvl;
    endcase

    sh_d = act_edge ? shifted : sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end
endmodule

// File: rtl/ssr_pair_asm.sv
module ssr_pair_asm #(
  parameter int MAX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_stb,
  input  logic [MAX_W-1:0] word_data,
  input  logic             word_left,
  input  logic             dsp_mode,
  output logic [MAX_W-1:0] left_o,
  output logic [MAX_W-1:0] right_o,
  output logic             pair_vld
);
  logic [MAX_W-1:0] hold_q, hold_d;
  logic [MAX_W-1:0] left_q, left_d;
  logic [MAX_W-1:0] right_q, right_d;
  logic             have_q, have_d;
  logic             vld_q, vld_d;
  logic             take_first, close;

  always_comb begin
    take_first = word_stb & (dsp_mode ? ~have_q : word_left);
    close      = word_stb & have_q & (dsp_mode | ~word_left);

    hold_d  = take_first ? word_data : hold_q;
    have_d  = take_first | (have_q & ~close);
    left_d  = close ? hold_q : left_q;
    right_d = close ? word_data : right_q;
    vld_d   = close;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      have_q  <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      have_q  <= have_d;
      left_q  <= left_d;
      right_q <= right_d;
      vld_q   <= vld_d;
    end
  end

  assign left_o   = left_q;
  assign right_o  = right_q;
  assign pair_vld = vld_q;

  // R10: a pair is only emitted when a first word was being held
  p_pair_after_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld |-> $past(have_q));

  // R10: the strobe lasts a single cycle
  p_vld_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld |=> !pair_vld);

  // R10: samples move only with the strobe
  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_vld |-> ($stable(left_o) && $stable(right_o)));
endmodule

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx
  import ssr_pkg::*;
#(
  parameter int MAX_W     = 24,
  parameter int MIN_W     = 16,
  parameter int SLOT_BITS = 32,
  localparam int CNT_W    = $clog2(2 * SLOT_BITS),
  localparam int LEN_W    = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       fmt_sel,
  input  logic [LEN_W-1:0] word_len,
  input  logic             bclk_inv,
  input  logic             lrclk_inv,
  input  logic             bclk_in,
  input  logic             lrclk_in,
  input  logic             sdata_in,
  output logic [MAX_W-1:0] left_out,
  output logic [MAX_W-1:0] right_out,
  output logic             valid_out
);
  logic             rst_meta, rst_int;
  ssr_fmt_e         fmt;
  logic             dsp_mode, frame_lvl;
  logic             act_edge, bound, prev_lvl, synced;
  logic [CNT_W-1:0] slot_idx;
  logic             word_stb, word_left;
  logic [MAX_W-1:0] word_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_int, rst_meta} <= 2'b00;
    else        {rst_int, rst_meta} <= {rst_meta, 1'b1};
  end

  always_comb begin
    fmt       = ssr_fmt_e'(fmt_sel);
    dsp_mode  = (fmt == FMT_DSP);
    frame_lvl = lrclk_in ^ lrclk_inv;
  end

  ssr_bclk_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_int),
    .bclk_in  (bclk_in),
    .bclk_inv (bclk_inv),
    .act_edge (act_edge)
  );

  ssr_slot_track #(.CNT_W(CNT_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_int),
    .act_edge  (act_edge),
    .frame_lvl (frame_lvl),
    .dsp_mode  (dsp_mode),
    .bound     (bound),
    .slot_idx  (slot_idx),
    .prev_lvl  (prev_lvl),
    .synced    (synced)
  );

  ssr_word_cap #(
    .MAX_W (MAX_W),
    .MIN_W (MIN_W),
    .CNT_W (CNT_W),
    .LEN_W (LEN_W)
  ) u_cap (
    .clk       (clk),
    .rst_n     (rst_int),
    .act_edge  (act_edge),
    .bound     (bound),
    .slot_idx  (slot_idx),
    .prev_lvl  (prev_lvl),
    .frame_lvl (frame_lvl),
    .synced    (synced),
    .fmt       (fmt),
    .word_len  (word_len),
    .sdata     (sdata_in),
    .word_stb  (word_stb),
    .word_data (word_data),
    .word_left (word_left)
  );

  ssr_pair_asm #(.MAX_W(MAX_W)) u_pair (
    .clk       (clk),
    .rst_n     (rst_int),
    .word_stb  (word_stb),
    .word_data (word_data),
    .word_left (word_left),
    .dsp_mode  (dsp_mode),
    .left_o    (left_out),
    .right_o   (right_out),
    .pair_vld  (valid_out)
  );

  // R2: a new pair can only follow an active bit-clock edge
  p_vld_follows_edge_r2: assert property (@(posedge clk) disable iff (!rst_int)
    valid_out |-> $past(act_edge));

  // R11: no strobe before the first frame boundary has been seen
  p_no_vld_unsynced_r11: assert property (@(posedge clk) disable iff (!rst_int)
    !synced |-> !valid_out);
endmodule

// File: tb/sim_stereo_serial_rx.sv
module sim_stereo_serial_rx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  fmt_sel;
  logic [4:0]  word_len;
  logic        bclk_inv, lrclk_inv, bclk_in, lrclk_in, sdata_in;
  logic [23:0] left_out, right_out;
  logic        valid_out;

  always #5 clk = ~clk;

  stereo_serial_rx u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt_sel   (fmt_sel),
    .word_len  (word_len),
    .bclk_inv  (bclk_inv),
    .lrclk_inv (lrclk_inv),
    .bclk_in   (bclk_in),
    .lrclk_in  (lrclk_in),
    .sdata_in  (sdata_in),
    .left_out  (left_out),
    .right_out (right_out),
    .valid_out (valid_out)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  logic [23:0] exp_l [0:15];
  logic [23:0] exp_r [0:15];
  int          exp_wr, exp_rd;
  bit          mon_en = 1'b0;
  int          pulse_err, hold_err;
  logic        prev_vld;
  logic [23:0] last_l, last_r;
  string       grp_tag;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [23:0] act, input logic [23:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (valid_out) begin
        if (prev_vld) pulse_err++;
        if (exp_rd < exp_wr) begin
          chk(left_out == exp_l[exp_rd], grp_tag, "left sample", left_out, exp_l[exp_rd]);
          chk(right_out == exp_r[exp_rd], grp_tag, "right sample", right_out, exp_r[exp_rd]);
        end
        exp_rd++;
      end else if (left_out != last_l || right_out != last_r) begin
        hold_err++;
      end
      last_l   = left_out;
      last_r   = right_out;
      prev_vld = valid_out;
    end
  end

  function automatic logic slot_bit(input int f, input int n, input logic [23:0] w,
                                    input int idx, input logic junk);
    case (f)
      1:       return (idx < n) ? w[n-1-idx] : junk;
      2:       return (idx >= 32 - n) ? w[31-idx] : junk;
      default: return (idx >= 1 && idx <= n) ? w[n-idx] : junk;
    endcase
  endfunction

  function automatic logic [23:0] aligned(input logic [23:0] w, input int n);
    logic [23:0] m;
    m = 24'hFFFFFF >> (24 - n);
    return (w & m) << (24 - n);
  endfunction

  // inactive phase carries the new data, then one active edge
  task automatic put_bit(input logic lvl, input logic d);
    @(negedge clk);
    bclk_in  = 1'b0 ^ bclk_inv;
    lrclk_in = lvl ^ lrclk_inv;
    sdata_in = d;
    repeat (1 + $urandom_range(0, 2)) @(negedge clk);
    bclk_in = 1'b1 ^ bclk_inv;
    @(negedge clk);
  endtask

  task automatic send_pair(input int f, input int n, input logic [23:0] lw, input logic [23:0] rw);
    logic left_lvl;
    exp_l[exp_wr] = aligned(lw, n);
    exp_r[exp_wr] = aligned(rw, n);
    exp_wr++;
    left_lvl = (f == 0) ? 1'b0 : 1'b1;
    for (int h = 0; h < 2; h++) begin
      for (int idx = 0; idx < 32; idx++) begin
        if (f == 3)
          put_bit(idx == 0, slot_bit(f, n, (h == 0) ? lw : rw, idx, 1'($urandom_range(0, 1))));
        else
          put_bit((h == 0) ? left_lvl : ~left_lvl,
                  slot_bit(f, n, (h == 0) ? lw : rw, idx, 1'($urandom_range(0, 1))));
      end
    end
  endtask

  task automatic run_group(input int f, input int wl, input logic bi, input logic li, input bit directed);
    int          n;
    logic        left_lvl;
    logic [23:0] lw, rw;
    string       ft;
    n = (wl < 16) ? 16 : (wl > 24) ? 24 : wl;
    left_lvl = (f == 0) ? 1'b0 : 1'b1;
    case (f)
      0: ft = "R4";
      1: ft = "R5";
      2: ft = "R6";
      default: ft = "R7";
    endcase
    grp_tag = $sformatf("R1 R2 R3 %s R8 R9 (fmt %0d len %0d)", ft, f, wl);

    rst_n     = 1'b0;
    fmt_sel   = 2'(f);
    word_len  = 5'(wl);
    bclk_inv  = bi;
    lrclk_inv = li;
    bclk_in   = bi;
    lrclk_in  = li;
    sdata_in  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk(left_out == 24'h0 && right_out == 24'h0 && valid_out == 1'b0, "R11",
        "reset outputs", left_out | right_out | {23'h0, valid_out}, 24'h0);

    exp_wr = 0; exp_rd = 0; pulse_err = 0; hold_err = 0;
    prev_vld = 1'b0; last_l = left_out; last_r = right_out;
    mon_en = 1'b1;

    // lead-in half of filler at the non-left level (R11: nothing taken yet)
    for (int idx = 0; idx < 32; idx++)
      put_bit((f == 3) ? 1'b0 : ~left_lvl, 1'($urandom_range(0, 1)));

    for (int k = 0; k < 4; k++) begin
      lw = 24'($urandom);
      rw = 24'($urandom);
      if (directed && k == 0) begin lw = 24'hFFFFFF; rw = 24'h000000; end
      if (directed && k == 1) begin lw = 24'h000000; rw = 24'hFFFFFF; end
      send_pair(f, n, lw, rw);
    end

    // tail half: closes the last right-justified word
    for (int idx = 0; idx < 32; idx++)
      put_bit((f == 3) ? 1'b0 : left_lvl, 1'($urandom_range(0, 1)));
    repeat (4) @(negedge clk);
    mon_en = 1'b0;

    chk(exp_rd == 4, "R10", "pairs emitted", 24'(exp_rd), 24'd4);
    chk(pulse_err == 0, "R10", "strobe width errors", 24'(pulse_err), 24'd0);
    chk(hold_err == 0, "R10", "outputs moved without strobe", 24'(hold_err), 24'd0);
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5EED);
    for (int f = 0; f < 4; f++) begin
      run_group(f, 16, 1'b0, 1'b0, 1'b1);
      run_group(f, 24, 1'b1, 1'b0, 1'b0);
      run_group(f, 20, 1'b1, 1'b1, 1'b0);
      run_group(f, (f % 2 == 1) ? 7 : 31, 1'b0, 1'b1, 1'b0); // R8 clamping
      run_group(f, 16 + $urandom_range(0, 8), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), 1'b0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule